// File: doc/BRIEF.md
# Framebuffer Scan-Out Display Controller

This block scans a true-colour image out of memory onto a pixel bus with horizontal sync, vertical sync and data-enable. A raster counter walks a fixed 640 by 480 visible area inside an 800 by 525 total timing. For every visible pixel of an enabled frame the block issues one read on a fixed-latency memory port. It splits the returned 32-bit word into 8-bit red, green and blue outputs. The sync and enable outputs are delayed by the same two clocks, so the colour data lines up with them.

Software sees two word registers, selected by one bit. One holds the frame base address; only its top 11 bits steer addressing. The other holds an enable bit and a rotation bit. With rotation set, the whole scan runs backwards, which turns the picture by 180 degrees. Base and rotation are copied into working state only when vertical blanking begins, so a frame is never split between two settings. The enable copy is taken at every line start.

Top module: `fb_scanout`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks (default 640+16+96+48). `hsync_n` is low for H_SYNC clocks that begin H_ACT+H_FP clocks into the line. A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines (default 480+10+2+33). `vsync_n` is low for V_SYNC lines that begin V_ACT+V_FP lines into the frame. Both syncs are delayed by two clocks, the same as `de`.
- R2: `de` is high for exactly the first H_ACT clocks of each of the first V_ACT lines, two clocks after the matching read request. It does not depend on the enable bit.
- R3: With the display enabled, `mem_rd_en` is high for exactly one clock per visible pixel and low in every blanking clock.
- R4: With rotation clear, the byte address of pixel (column c, row r) is B + r*4096 + c*4. The row pitch is 1024 words, and columns 640 to 1023 are never read.
- R5: B is {base[31:21], 21'b0}. Base bits 20:0 have no effect on any address.
- R6: With rotation set, the pixel at screen position (c, r) is read from column H_ACT-1-c of row V_ACT-1-r.
- R7: While `de` is high and the display is enabled, `red`=word[23:16], `green`=word[15:8] and `blue`=word[7:0] of the returned word. Bits 31:24 are ignored.
- R8: With the display disabled, no reads are issued, and `red`, `green` and `blue` are zero. They are also zero whenever `de` is low.
- R9: A write to the base or rotation bit takes effect at the first clock edge that ends the last visible line. Earlier lines of the current frame are unchanged.
- R10: A write to the enable bit takes effect at the next line start.
- R11: With `reg_sel`=0, `reg_rdata` returns the full stored base word. With `reg_sel`=1, it returns the control word, with bit 0 as enable, bit 1 as rotate and bits 31:2 as zero. Reset clears both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 32 | Read data, valid two clocks after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The assertions check properties that must hold on every cycle:
- colour outputs are black outside `de`;
- every read is followed two clocks later by `de`;
- read addresses are word-aligned and inside the visible columns;
- the sync pulse has its minimum width;
- unused control bits read as zero.

Only the bench's frame-by-frame scenarios can show that the exact address sequence is correct under rotation and a misaligned base. They also show that register writes land at the vertical-blanking or line boundary and not earlier.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_ACT      = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_ACT      = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  parameter int PITCH_LOG2 = 10,
  parameter int BASE_KEEP  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic [31:0] mem_rd_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        de,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue
);
  localparam int HT   = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT   = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW   = $clog2(HT);
  localparam int VW   = $clog2(VT);
  localparam int BLSB = 32 - BASE_KEEP;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [31:0]   base_reg;
  logic [1:0]    ctrl_reg;
  logic [BASE_KEEP-1:0] base_live;
  logic          rot_live, en_live;

  logic line_end, vblank_go, visible, hs_raw, vs_raw;
  logic [VW-1:0] row;
  logic [HW-1:0] col;

  assign line_end  = hcnt == HW'(HT - 1);
  assign vblank_go = line_end && vcnt == VW'(V_ACT - 1);
  assign visible   = hcnt < HW'(H_ACT) && vcnt < VW'(V_ACT);
  assign hs_raw    = !(hcnt >= HW'(H_ACT + H_FP) && hcnt < HW'(H_ACT + H_FP + H_SYNC));
  assign vs_raw    = !(vcnt >= VW'(V_ACT + V_FP) && vcnt < VW'(V_ACT + V_FP + V_SYNC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= (vcnt == VW'(VT - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_reg <= '0;
      ctrl_reg <= '0;
    end else if (reg_we) begin
      if (reg_sel) ctrl_reg <= reg_wdata[1:0];
      else         base_reg <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? {30'b0, ctrl_reg} : base_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_live <= '0;
      rot_live  <= 1'b0;
      en_live   <= 1'b0;
    end else begin
      if (line_end) en_live <= ctrl_reg[0];
      if (vblank_go) begin
        base_live <= base_reg[31:BLSB];
        rot_live  <= ctrl_reg[1];
      end
    end
  end

  assign row = rot_live ? VW'(V_ACT - 1) - vcnt : vcnt;
  assign col = rot_live ? HW'(H_ACT - 1) - hcnt : hcnt;

  assign mem_rd_en   = visible && en_live;
  assign mem_rd_addr = {base_live, {BLSB{1'b0}}}
                     + (32'(row) << (PITCH_LOG2 + 2))
                     + (32'(col) << 2);

  logic [1:0] de_q, pv_q, hs_q, vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q <= '0;
      pv_q <= '0;
      hs_q <= '1;
      vs_q <= '1;
    end else begin
      de_q <= {de_q[0], visible};
      pv_q <= {pv_q[0], mem_rd_en};
      hs_q <= {hs_q[0], hs_raw};
      vs_q <= {vs_q[0], vs_raw};
    end
  end

  assign de      = de_q[1];
  assign hsync_n = hs_q[1];
  assign vsync_n = vs_q[1];
  assign red     = pv_q[1] ? mem_rd_data[23:16] : 8'h00;
  assign green   = pv_q[1] ? mem_rd_data[15:8]  : 8'h00;
  assign blue    = pv_q[1] ? mem_rd_data[7:0]   : 8'h00;
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int H_ACT      = 640,
  parameter int H_SYNC     = 96,
  parameter int PITCH_LOG2 = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic [31:0] reg_rdata,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        hsync_n,
  input logic        de,
  input logic [7:0]  red,
  input logic [7:0]  green,
  input logic [7:0]  blue
);
  a_r8_black_outside_de: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (red == 8'h00 && green == 8'h00 && blue == 8'h00));

  a_r2_de_two_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ##2 de);

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr[1:0] == 2'b00);

  a_r4_column_visible: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> int'(mem_rd_addr[PITCH_LOG2+1:2]) < H_ACT);

  generate
    if (H_SYNC > 1) begin : g_hw
      a_r1_hsync_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |=> !hsync_n);
    end
  endgenerate

  a_r11_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata[31:2] == 30'b0);
endmodule

bind fb_scanout fb_scanout_chk #(.H_ACT(H_ACT), .H_SYNC(H_SYNC), .PITCH_LOG2(PITCH_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .hsync_n(hsync_n),
  .de(de), .red(red), .green(green), .blue(blue));

// File: tb/fb_scanout_tb.sv
`timescale 1ns/1ps
module fb_scanout_tb_top;
  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 2;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_rd_addr, mem_rd_data;
  logic mem_rd_en, hsync_n, vsync_n, de;
  logic [7:0] red, green, blue;

  always #10 clk = ~clk;

  fb_scanout #(.H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
               .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de), .red(red), .green(green), .blue(blue));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ (a >> 7);
  endfunction

  logic [31:0] m1, m2;
  always @(posedge clk) begin
    m1 <= mem_rd_en ? memf(mem_rd_addr) : 32'hDEAD_BEEF;
    m2 <= m1;
  end
  assign mem_rd_data = m2;

  int errors = 0, checks = 0;
  bit run_checks = 1'b0, done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  int mh, mv;
  logic [31:0] sw_base;
  logic [1:0]  sw_ctrl;
  logic [10:0] l_base;
  logic l_rot, l_en;
  logic c_vis, c_en, c_hs, c_vs;
  logic [31:0] c_addr;
  logic [1:0] e_de, e_pv, e_hs, e_vs;
  logic [31:0] e_a1, e_a2;

  always_comb begin
    c_vis  = mh < H_ACT && mv < V_ACT;
    c_en   = c_vis && l_en;
    c_hs   = !(mh >= H_ACT + H_FP && mh < H_ACT + H_FP + H_SYNC);
    c_vs   = !(mv >= V_ACT + V_FP && mv < V_ACT + V_FP + V_SYNC);
    c_addr = {l_base, 21'b0}
           + 32'((l_rot ? V_ACT - 1 - mv : mv) * 4096)
           + 32'((l_rot ? H_ACT - 1 - mh : mh) * 4);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0; sw_base <= '0; sw_ctrl <= '0;
      l_base <= '0; l_rot <= 1'b0; l_en <= 1'b0;
      e_de <= '0; e_pv <= '0; e_hs <= '1; e_vs <= '1; e_a1 <= '0; e_a2 <= '0;
    end else begin
      if (reg_we) begin
        if (reg_sel) sw_ctrl <= reg_wdata[1:0];
        else         sw_base <= reg_wdata;
      end
      if (mh == HT - 1) begin
        mh   <= 0;
        mv   <= (mv == VT - 1) ? 0 : mv + 1;
        l_en <= sw_ctrl[0];
        if (mv == V_ACT - 1) begin
          l_base <= sw_base[31:21];
          l_rot  <= sw_ctrl[1];
        end
      end else begin
        mh <= mh + 1;
      end
      e_de <= {e_de[0], c_vis};
      e_pv <= {e_pv[0], c_en};
      e_hs <= {e_hs[0], c_hs};
      e_vs <= {e_vs[0], c_vs};
      e_a1 <= c_addr;
      e_a2 <= e_a1;
    end
  end

  always @(negedge clk) begin
    if (run_checks) begin
      check("R3 R8 R10 read enable", {31'b0, mem_rd_en}, {31'b0, c_en});
      if (c_en) check("R4 R5 R6 R9 address", mem_rd_addr, c_addr);
      check("R2 data enable", {31'b0, de}, {31'b0, e_de[1]});
      check("R1 hsync", {31'b0, hsync_n}, {31'b0, e_hs[1]});
      check("R1 vsync", {31'b0, vsync_n}, {31'b0, e_vs[1]});
      check("R7 R8 pixel", {8'h00, red, green, blue},
            e_pv[1] ? {8'h00, memf(e_a2)[23:0]} : 32'h0);
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset base", reg_rdata, 32'h0);
    check("R8 reset pixel", {8'h00, red, green, blue}, 32'h0);
    check("R2 reset de", {31'b0, de}, 32'h0);
    check("R3 reset read", {31'b0, mem_rd_en}, 32'h0);
    rst_n = 1'b1;
    run_checks = 1'b1;
    rd("R11 ctrl after reset", 1'b1, 32'h0);
    repeat (FRAME / 2) @(negedge clk);
    wr(1'b0, 32'h1234_5678);
    wr(1'b1, 32'h0000_0001);
    rd("R11 base readback", 1'b0, 32'h1234_5678);
    repeat (2 * FRAME + 5) @(negedge clk);
    wr(1'b1, 32'hFFFF_FFFF);
    rd("R11 ctrl masked", 1'b1, 32'h0000_0003);
    wr(1'b0, 32'hFFE0_0000);
    repeat (2 * FRAME + 7) @(negedge clk);
    wr(1'b1, 32'h0000_0002);
    repeat (FRAME + 3) @(negedge clk);
    wr(1'b0, 32'h003F_FFFC);
    wr(1'b1, 32'h0000_0001);
    repeat (2 * FRAME) @(negedge clk);
    wr(1'b1, 32'h0000_0000);
    repeat (FRAME / 3) @(negedge clk);
    wr(1'b1, 32'h0000_0003);
    repeat (2 * FRAME) @(negedge clk);
    run_checks = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule